// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block derives a steady one-microsecond tick from whatever reference clock feeds it. The conversion is set by a programmable ratio of two small integers. On every reference cycle the block adds the numerator to an accumulator. Each time the accumulator passes the denominator, the block emits a one-cycle tick and keeps the remainder. Because the remainder is never thrown away, a reference such as 19.2 MHz yields exactly five ticks in every 96 cycles, which averages exactly 1 MHz.

The ticks drive a free-running microsecond counter. Software reads this counter over a simple register bus. The same bus reads and writes the ratio register. The tick is also exported for downstream timers. Each write to the ratio register restarts the accumulator, so a new ratio starts from a known phase.

Top module: `usec_timebase`

## Requirements
- R1: While reset is asserted, the ratio register reads 0x0000000B, the counter reads 0, and `tick_o` is low.
- R2: A write to address 0x14 stores `bus_wdata[15:0]` as the ratio register. Bits [15:8] hold the numerator minus one and bits [7:0] hold the denominator minus one. Reads of 0x14 return the stored value with bits [31:16] zero. The register changes only on such a write.
- R3: Reads of address 0x10 return the counter, zero-extended to 32 bits. A write to 0x10 changes nothing. A read of any other address returns zero.
- R4: With numerator D smaller than denominator V, the ticks in the first k cycles after a ratio write number exactly floor(k·D/V). The accumulator always stays below V.
- R5: The ratio values 0x000B, 0x000C, 0x045F and 0x0019 give exactly 100 ticks in 1200, 1300, 1920 and 2600 cycles respectively. These are the values for 12, 13, 19.2 and 26 MHz references.
- R6: The counter increases by exactly one in the cycle after `tick_o` is high. It holds its value otherwise.
- R7: The counter is `CNT_W` bits wide (32 by default) and wraps modulo 2^CNT_W.
- R8: In the cycle after a ratio write, the accumulator is zero and `tick_o` is low. The counter is not disturbed.
- R9: When D is greater than or equal to V, `tick_o` is high on every cycle that does not follow a ratio write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_o | output | 1 | One-cycle microsecond tick |

## Verification
The ratio is tried with the four standard reference settings over long windows. These show that the remainder is carried exactly: an off-by-one in the compare or the subtraction would drift by a tick or more over 100 periods. Short windows ending one cycle before and on the first tick separate a correct phase after a write from an early or late one. An odd ratio with 3 over 255 exercises remainders that do not divide evenly.

Ratios with a numerator at or above the denominator check the one-tick-per-cycle ceiling. A narrow-counter instance run past its limit checks the wrap. Writes to the counter address, to unmapped addresses and to the ratio register are read back to show which state each one can and cannot touch.

// File: rtl/usec_pkg.sv
package usec_pkg;
    localparam int FRAC_W = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 2 * FRAC_W;

    localparam logic [ADDR_W-1:0] ADDR_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_RATIO = 8'h14;
    localparam logic [CFG_W-1:0]  RATIO_RST  = 16'h000B;

    typedef struct packed {
        logic [FRAC_W-1:0] num_m1;
        logic [FRAC_W-1:0] den_m1;
    } ratio_t;

    function automatic logic [FRAC_W:0] plus_one(input logic [FRAC_W-1:0] v);
        return {1'b0, v} + {{FRAC_W{1'b0}}, 1'b1};
    endfunction
endpackage

// File: rtl/usec_cfg_reg.sv
module usec_cfg_reg
    import usec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wdata,
    output ratio_t              ratio_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= ratio_t'(RATIO_RST);
        end else if (wr_en) begin
            ratio_q <= ratio_t'(wdata);
        end
    end
endmodule

// File: rtl/usec_frac_accum.sv
module usec_frac_accum
    import usec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [FRAC_W:0]     num,
    input  logic [FRAC_W:0]     den,
    output logic                tick_o,
    output logic [FRAC_W+1:0]   acc_q
);
    localparam int ACC_W = FRAC_W + 2;

    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] den_x;
    logic             saturate;

    assign den_x    = {1'b0, den};
    assign sum      = acc_q + {1'b0, num};
    assign saturate = (num >= den);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (saturate) begin
            acc_q  <= '0;
            tick_o <= 1'b1;
        end else if (sum >= den_x) begin
            acc_q  <= sum - den_x;
            tick_o <= 1'b1;
        end else begin
            acc_q  <= sum;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + STEP;
        end
    end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tick_o
);
    ratio_t              ratio_q;
    logic                cfg_wr;
    logic [FRAC_W:0]     num;
    logic [FRAC_W:0]     den;
    logic [FRAC_W+1:0]   acc_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DATA_W-1:0]   cnt_rd;

    assign cfg_wr = bus_wr && (bus_addr == ADDR_RATIO);
    assign num    = plus_one(ratio_q.num_m1);
    assign den    = plus_one(ratio_q.den_m1);

    usec_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wdata   (bus_wdata[CFG_W-1:0]),
        .ratio_q (ratio_q)
    );

    usec_frac_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (cfg_wr),
        .num    (num),
        .den    (den),
        .tick_o (tick_o),
        .acc_q  (acc_q)
    );

    usec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (tick_o),
        .cnt_q (cnt_q)
    );

    generate
        if (CNT_W < DATA_W) begin : g_narrow
            assign cnt_rd = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
        end else begin : g_full
            assign cnt_rd = cnt_q[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        case (bus_addr)
            ADDR_COUNT: bus_rdata = cnt_rd;
            ADDR_RATIO: bus_rdata = {{(DATA_W-CFG_W){1'b0}}, ratio_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
    import usec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              tick_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [FRAC_W+1:0] acc_q,
    input logic [FRAC_W:0]   num,
    input logic [FRAC_W:0]   den,
    input logic [CFG_W-1:0]  ratio
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == $past(cnt_q) + ONE));

    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(cnt_q));

    p_wr_clears_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (acc_q == '0 && !tick_o));

    p_acc_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, acc_q} < {2'b00, den}));

    p_ratio_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(ratio));

    p_full_rate_r9: assert property (@(posedge clk) disable iff (rst)
        (num >= den && !cfg_wr) |=> tick_o);
endmodule

bind usec_timebase usec_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_wr (cfg_wr),
    .tick_o (tick_o),
    .cnt_q  (cnt_q),
    .acc_q  (acc_q),
    .num    (num),
    .den    (den),
    .ratio  (ratio_q)
);

// File: tb/usec_timebase_bench.sv
module usec_timebase_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic [7:0]  addr, addr_w;
    logic        wr, wr_w;
    logic [31:0] wdata, wdata_w, rdata, rdata_w;
    logic        tick, tick_w;

    usec_timebase u_usec_timebase (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .tick_o(tick)
    );

    usec_timebase #(.CNT_W(8)) u_wrap (
        .clk(clk), .rst(rst), .bus_addr(addr_w), .bus_wr(wr_w),
        .bus_wdata(wdata_w), .bus_rdata(rdata_w), .tick_o(tick_w)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        string  req;
        longint exp;
    } item_t;
    item_t sb_q[$];

    task automatic push_exp(input string req, input longint exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic observe(input longint act);
        item_t it;
        checks++;
        if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty: actual=%0d expected=none", act);
        end else begin
            it = sb_q.pop_front();
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s: actual=%0d expected=%0d", it.req, act, it.exp);
            end
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Write a ratio, then count ticks over k cycles and the counter delta.
    task automatic measure(input logic [15:0] cfg, input int k, input string req);
        longint num, den, exp_t, exp_d;
        logic [31:0] ca, cb, diff;
        int ntick;
        num = longint'(cfg[15:8]) + 1;
        den = longint'(cfg[7:0]) + 1;
        if (num >= den) begin
            exp_t = k;
            exp_d = k - 1;
        end else begin
            exp_t = (longint'(k) * num) / den;
            exp_d = (longint'(k - 1) * num) / den;
        end
        bus_write(8'h14, {16'h0, cfg});
        bus_read(8'h10, ca);
        push_exp("R8 tick after write", 0);
        observe(longint'(tick));
        ntick = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            #1;
            ntick += int'(tick);
        end
        bus_read(8'h10, cb);
        diff = cb - ca;
        push_exp(req, exp_t);
        observe(longint'(ntick));
        push_exp("R6 counter delta", exp_d);
        observe(longint'(diff));
    endtask

    initial begin
        logic [31:0] v, c0, c1;
        rst = 1'b1; addr = 8'h10; wr = 1'b0; wdata = '0;
        addr_w = 8'h10; wr_w = 1'b0; wdata_w = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_read(8'h10, v); push_exp("R1 counter", 0); observe(longint'(v));
        bus_read(8'h14, v); push_exp("R1 ratio", 32'h0000000B); observe(longint'(v));
        push_exp("R1 tick", 0); observe(longint'(tick));
        rst = 1'b0;

        // R5 standard reference settings
        measure(16'h000B, 1200, "R5 12MHz");
        measure(16'h000C, 1300, "R5 13MHz");
        measure(16'h045F, 1920, "R5 19.2MHz");
        measure(16'h0019, 2600, "R5 26MHz");

        // R4 phase of first tick and odd remainder
        measure(16'h000B, 11, "R4 before first tick");
        measure(16'h000B, 12, "R4 on first tick");
        measure(16'h045F, 19, "R4 fractional before");
        measure(16'h045F, 20, "R4 fractional on");
        measure(16'h02FE, 1000, "R4 odd ratio");

        // R9 ceiling of one tick per cycle
        measure(16'h0300, 50, "R9 num above den");
        measure(16'h0707, 50, "R9 num equals den");

        // R2 store and read back
        bus_write(8'h14, 32'hABCD1234);
        bus_read(8'h14, v); push_exp("R2 readback", 32'h00001234); observe(longint'(v));

        // R3 counter not writable, unmapped reads zero
        measure(16'h00FF, 100, "R4 slow ratio");
        bus_read(8'h10, c0);
        bus_write(8'h10, 32'hDEADBEEF);
        bus_read(8'h10, c1);
        push_exp("R3 counter write ignored", longint'(c0)); observe(longint'(c1));
        bus_read(8'h14, v); push_exp("R3 ratio untouched", 32'h000000FF); observe(longint'(v));
        bus_read(8'h20, v); push_exp("R3 unmapped read", 0); observe(longint'(v));

        // R7 wrap on the 8-bit instance, ticking every cycle
        @(negedge clk);
        addr_w = 8'h14; wdata_w = 32'h0; wr_w = 1'b1;
        @(negedge clk);
        wr_w = 1'b0; addr_w = 8'h10;
        #1; c0 = rdata_w;
        repeat (300) @(negedge clk);
        #1; c1 = rdata_w;
        push_exp("R7 wrap", longint'((c0 + 32'd299) & 32'hFF)); observe(longint'(c1));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule